// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is a small memory-mapped mailbox between a host register port and a responder agent, such as a power-management controller. Before issuing a request, the host loads two pointer registers and up to four 32-bit words of request payload. It then writes a command word. That write rings a one-cycle doorbell towards the responder, and the mailbox is marked busy.

The responder reads the latched command, the pointers and the payload from dedicated outputs. It may deposit up to four response words into an inbound buffer. It finishes the request with a done pulse, which can carry an error flag and an 8-bit error code.

The mailbox records three status flags: busy, error and completion. It raises a host interrupt when the completed command asked for one. The host clears the completion flag by writing a one to it.

Register map (byte offsets):

| Offset | Register |
|---|---|
| 0x00 | Command word |
| 0x04 | Status |
| 0x08 | Destination pointer |
| 0x0C | Source pointer |
| 0x80 + 4*i | Outbound payload word i |
| 0x90 + 4*i | Inbound response word i |

Command word fields:

| Bits | Field |
|---|---|
| 7:0 | Command code |
| 8 | Interrupt request |
| 15:12 | Subcommand |
| 23:16 | Payload length in bytes |

Status word fields:

| Bits | Field |
|---|---|
| 0 | Busy |
| 1 | Error |
| 2 | Completion flag |
| 23:16 | Error code |

Host reads are combinational from `hst_addr`.

Top module: `doorbell_mbx`

## Requirements
- R1: After reset, every register, including the status word, reads 0, and `host_irq` and `rsp_ring` are low.
- R2: A host write to offset 0x00 while not busy latches the word. Status bit 0 (busy) reads 1 from the next cycle. `rsp_ring` is high for exactly the one cycle after the write edge. `rsp_cmd` presents the word.
- R3: A host write to offset 0x00 while busy is ignored. `rsp_ring` stays low and offset 0x00 still reads the earlier word.
- R4: Offset 0x08 (destination pointer) and offset 0x0C (source pointer) are read/write and drive `rsp_dptr` and `rsp_sptr`.
- R5: Outbound word i is written and read at offset 0x80+4*i. It appears on `rsp_obuf` bits 32*i+31:32*i.
- R6: A responder write with `rsp_we` and index i stores `rsp_wdata`, which the host reads at 0x90+4*i. Host writes to 0x90..0x9C have no effect.
- R7: A `rsp_done` pulse while busy has the following effect from the next cycle:
  - busy clears;
  - status bit 2 sets;
  - status bit 1 takes `rsp_err`;
  - status bits 23:16 take `rsp_code` when `rsp_err` is 1, and take 0 otherwise.
- R8: An accepted command write clears status bit 1 and bits 23:16.
- R9: A host write to offset 0x04 with bit 2 set clears status bit 2. Other written bits have no effect. A done pulse in the same cycle wins, and the bit stays set.
- R10: `host_irq` is high exactly when status bit 2 is set and bit 8 of the latched command word is 1.
- R11: A `rsp_done` pulse while not busy changes no status bit.
- R12: Offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | AW (8) | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt to host |
| rsp_ring | output | 1 | One-cycle doorbell to responder |
| rsp_cmd | output | 32 | Latched command word |
| rsp_dptr | output | 32 | Destination pointer |
| rsp_sptr | output | 32 | Source pointer |
| rsp_obuf | output | 32*NWORDS | Outbound payload, word i in bits 32*i+31:32*i |
| rsp_we | input | 1 | Responder write strobe into inbound buffer |
| rsp_widx | input | IDXW (2) | Inbound word index |
| rsp_wdata | input | 32 | Inbound word data |
| rsp_done | input | 1 | Completion pulse |
| rsp_err | input | 1 | Error flag qualifying `rsp_done` |
| rsp_code | input | 8 | Error code qualifying `rsp_done` |

## Verification
Each register write, command acceptance and done pulse takes effect on the clock edge where it is sampled. Status, pointer and buffer contents are therefore visible to a host read in the following cycle. `rsp_ring` is high only in the cycle right after the accepted command edge.

The bench drives every stimulus just after a falling edge and checks ports just after the next rising edge. Host reads use the address set just after one falling edge. A scoreboard holds the expected read value and compares it at the following falling edge. Ring checks are made both in the cycle right after the command edge and one cycle later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [15:0] OFS_CMD  = 16'h0000;
  localparam logic [15:0] OFS_STS  = 16'h0004;
  localparam logic [15:0] OFS_DPTR = 16'h0008;
  localparam logic [15:0] OFS_SPTR = 16'h000C;
  localparam logic [15:0] OFS_OBUF = 16'h0080;
  localparam logic [15:0] OFS_IBUF = 16'h0090;

  localparam int unsigned IRQ_REQ_BIT = 8;
  localparam int unsigned ACK_BIT     = 2;

  function automatic logic [REG_W-1:0] pack_status(input logic busy, input logic err,
                                                   input logic flag, input logic [7:0] code);
    return {8'h00, code, 13'h0000, flag, err, busy};
  endfunction

  function automatic logic in_window(input logic [15:0] addr, input logic [15:0] base,
                                     input int unsigned nwords);
    return (addr >= base) && (addr < base + 16'(4 * nwords)) && (addr[1:0] == 2'b00);
  endfunction

  function automatic logic [15:0] word_index(input logic [15:0] addr, input logic [15:0] base);
    return (addr - base) >> 2;
  endfunction
endpackage

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 4,
  localparam int unsigned IDXW  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDXW-1:0]      widx,
  input  logic [DW-1:0]        wdata,
  output logic [NWORDS*DW-1:0] flat
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              word_q <= '0;
      else if (we && (widx == IDXW'(g)))       word_q <= wdata;
    end
    assign flat[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_wdata,
  input  logic             ack_wr,
  input  logic             done,
  input  logic             err_in,
  input  logic [7:0]       code_in,
  output logic             cmd_accept,
  output logic             done_accept,
  output logic             busy,
  output logic             err,
  output logic             flag,
  output logic [7:0]       code,
  output logic [REG_W-1:0] cmd_q,
  output logic             ring
);
  assign cmd_accept  = cmd_wr & ~busy;
  assign done_accept = done & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err   <= 1'b0;
      flag  <= 1'b0;
      code  <= '0;
      cmd_q <= '0;
      ring  <= 1'b0;
    end else begin
      ring <= cmd_accept;
      if (cmd_accept) begin
        cmd_q <= cmd_wdata;
        busy  <= 1'b1;
        err   <= 1'b0;
        code  <= '0;
      end else if (done_accept) begin
        busy <= 1'b0;
        err  <= err_in;
        code <= err_in ? code_in : 8'h00;
      end
      if (done_accept)  flag <= 1'b1;
      else if (ack_wr)  flag <= 1'b0;
    end
  end
endmodule

// File: rtl/doorbell_mbx.sv
module doorbell_mbx
  import mbx_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned NWORDS = 4,
  localparam int unsigned IDXW  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hst_we,
  input  logic [AW-1:0]           hst_addr,
  input  logic [REG_W-1:0]        hst_wdata,
  output logic [REG_W-1:0]        hst_rdata,
  output logic                    host_irq,
  output logic                    rsp_ring,
  output logic [REG_W-1:0]        rsp_cmd,
  output logic [REG_W-1:0]        rsp_dptr,
  output logic [REG_W-1:0]        rsp_sptr,
  output logic [NWORDS*REG_W-1:0] rsp_obuf,
  input  logic                    rsp_we,
  input  logic [IDXW-1:0]         rsp_widx,
  input  logic [REG_W-1:0]        rsp_wdata,
  input  logic                    rsp_done,
  input  logic                    rsp_err,
  input  logic [7:0]              rsp_code
);
  logic [15:0] addr16;
  assign addr16 = 16'(hst_addr);

  logic hit_cmd, hit_sts, hit_dptr, hit_sptr, hit_obuf, hit_ibuf;
  assign hit_cmd  = (addr16 == OFS_CMD);
  assign hit_sts  = (addr16 == OFS_STS);
  assign hit_dptr = (addr16 == OFS_DPTR);
  assign hit_sptr = (addr16 == OFS_SPTR);
  assign hit_obuf = in_window(addr16, OFS_OBUF, NWORDS);
  assign hit_ibuf = in_window(addr16, OFS_IBUF, NWORDS);

  logic [IDXW-1:0] obuf_idx, ibuf_idx;
  assign obuf_idx = IDXW'(word_index(addr16, OFS_OBUF));
  assign ibuf_idx = IDXW'(word_index(addr16, OFS_IBUF));

  // named internal events
  logic cmd_wr_req, ack_wr, cmd_accept, done_accept;
  assign cmd_wr_req = hst_we & hit_cmd;
  assign ack_wr     = hst_we & hit_sts & hst_wdata[ACK_BIT];

  logic busy, err, flag;
  logic [7:0] code;
  logic [REG_W-1:0] cmd_q;

  mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr_req), .cmd_wdata(hst_wdata), .ack_wr(ack_wr),
    .done(rsp_done), .err_in(rsp_err), .code_in(rsp_code),
    .cmd_accept(cmd_accept), .done_accept(done_accept),
    .busy(busy), .err(err), .flag(flag), .code(code),
    .cmd_q(cmd_q), .ring(rsp_ring)
  );

  logic [NWORDS*REG_W-1:0] ibuf_flat;

  mbx_wordbuf #(.DW(REG_W), .NWORDS(NWORDS)) u_obuf (
    .clk(clk), .rst_n(rst_n), .we(hst_we & hit_obuf), .widx(obuf_idx),
    .wdata(hst_wdata), .flat(rsp_obuf)
  );

  mbx_wordbuf #(.DW(REG_W), .NWORDS(NWORDS)) u_ibuf (
    .clk(clk), .rst_n(rst_n), .we(rsp_we), .widx(rsp_widx),
    .wdata(rsp_wdata), .flat(ibuf_flat)
  );

  logic [REG_W-1:0] dptr_q, sptr_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dptr_q <= '0;
      sptr_q <= '0;
    end else if (hst_we) begin
      if (hit_dptr) dptr_q <= hst_wdata;
      if (hit_sptr) sptr_q <= hst_wdata;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (hit_obuf)      hst_rdata = rsp_obuf[obuf_idx*REG_W +: REG_W];
    else if (hit_ibuf) hst_rdata = ibuf_flat[ibuf_idx*REG_W +: REG_W];
    else if (hit_cmd)  hst_rdata = cmd_q;
    else if (hit_sts)  hst_rdata = pack_status(busy, err, flag, code);
    else if (hit_dptr) hst_rdata = dptr_q;
    else if (hit_sptr) hst_rdata = sptr_q;
  end

  assign rsp_cmd  = cmd_q;
  assign rsp_dptr = dptr_q;
  assign rsp_sptr = sptr_q;
  assign host_irq = flag & cmd_q[IRQ_REQ_BIT];
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr_req,
  input logic        cmd_accept,
  input logic        done_accept,
  input logic        ack_wr,
  input logic        rsp_done,
  input logic        busy,
  input logic        err,
  input logic        flag,
  input logic        rsp_ring,
  input logic        host_irq,
  input logic [31:0] cmd_q
);
  // R2
  ring_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> rsp_ring && busy);
  // R2
  ring_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ring |=> !rsp_ring);
  // R3
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_req && busy) |=> !rsp_ring && $stable(cmd_q));
  // R7
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_accept |=> !busy && flag);
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !err);
  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !done_accept) |=> !flag);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> flag && cmd_q[8]);
  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !busy && !ack_wr && !cmd_wr_req) |=> $stable(flag) && $stable(err) && !busy);
endmodule

bind doorbell_mbx mbx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr_req(cmd_wr_req), .cmd_accept(cmd_accept),
  .done_accept(done_accept), .ack_wr(ack_wr), .rsp_done(rsp_done),
  .busy(busy), .err(err), .flag(flag), .rsp_ring(rsp_ring),
  .host_irq(host_irq), .cmd_q(cmd_q)
);

// File: tb/doorbell_mbx_bench.sv
`timescale 1ns/1ps
module doorbell_mbx_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic         hst_we = 0;
  logic [7:0]   hst_addr = 0;
  logic [31:0]  hst_wdata = 0;
  logic [31:0]  hst_rdata;
  logic         host_irq, rsp_ring;
  logic [31:0]  rsp_cmd, rsp_dptr, rsp_sptr;
  logic [127:0] rsp_obuf;
  logic         rsp_we = 0;
  logic [1:0]   rsp_widx = 0;
  logic [31:0]  rsp_wdata = 0;
  logic         rsp_done = 0, rsp_err = 0;
  logic [7:0]   rsp_code = 0;

  doorbell_mbx u_doorbell_mbx (.*);

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] exp; logic [7:0] addr; string req; } rd_item_t;
  rd_item_t sbq[$];

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares host read data one cycle after the driver set the address
  always begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      rd_item_t it;
      it = sbq.pop_front();
      chk($sformatf("%s rd@%0h", it.req, it.addr), {96'h0, hst_rdata}, {96'h0, it.exp});
    end
  end

  function automatic logic [31:0] sts(input logic b, input logic e, input logic f, input logic [7:0] c);
    logic [31:0] v;
    v = 32'h0;
    v[0] = b; v[1] = e; v[2] = f; v[23:16] = c;
    return v;
  endfunction

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    rd_item_t it;
    @(negedge clk); #1;
    hst_addr = a;
    it.exp = exp; it.addr = a; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    hst_we = 1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_we = 0;
  endtask

  task automatic rsp_put(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk); #1;
    rsp_we = 1; rsp_widx = i; rsp_wdata = d;
    @(posedge clk); #1;
    rsp_we = 0;
  endtask

  task automatic finish_rsp(input logic e, input logic [7:0] c);
    @(negedge clk); #1;
    rsp_done = 1; rsp_err = e; rsp_code = c;
    @(posedge clk); #1;
    rsp_done = 0; rsp_err = 0; rsp_code = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 irq", host_irq, 0);
    chk("R1 ring", rsp_ring, 0);
    rd(8'h04, 32'h0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h80, 32'h0, "R1");
    rd(8'h90, 32'h0, "R1");

    // R4 pointers
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'hCAFE_0001);
    rd(8'h08, 32'h1234_5678, "R4");
    rd(8'h0C, 32'hCAFE_0001, "R4");
    chk("R4 dptr port", rsp_dptr, 32'h1234_5678);
    chk("R4 sptr port", rsp_sptr, 32'hCAFE_0001);

    // R5 outbound payload
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4*i), 32'hA000_0000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) rd(8'h80 + 8'(4*i), 32'hA000_0000 + 32'(i * 17), "R5");
    chk("R5 obuf port", rsp_obuf, {32'hA000_0033, 32'hA000_0022, 32'hA000_0011, 32'hA000_0000});

    // R2 command with irq request, sub 3, length 16
    wr(8'h00, 32'h0010_3121);
    chk("R2 ring high", rsp_ring, 1);
    chk("R2 cmd port", rsp_cmd, 32'h0010_3121);
    @(posedge clk); #1;
    chk("R2 ring one cycle", rsp_ring, 0);
    rd(8'h04, sts(1, 0, 0, 0), "R2");

    // R3 command while busy ignored
    wr(8'h00, 32'h0000_0055);
    chk("R3 no ring", rsp_ring, 0);
    @(posedge clk); #1;
    chk("R3 no ring later", rsp_ring, 0);
    rd(8'h00, 32'h0010_3121, "R3");

    // R6 inbound buffer
    rsp_put(2'd0, 32'h1111_0000);
    rsp_put(2'd3, 32'h3333_0003);
    wr(8'h90, 32'hDEAD_BEEF);
    rd(8'h90, 32'h1111_0000, "R6");
    rd(8'h9C, 32'h3333_0003, "R6");
    rd(8'h94, 32'h0, "R6");

    // R7 / R10 done without error
    finish_rsp(0, 8'h77);
    chk("R10 irq set", host_irq, 1);
    rd(8'h04, sts(0, 0, 1, 0), "R7");

    // R9 W1C
    wr(8'h04, 32'h0000_0003);
    rd(8'h04, sts(0, 0, 1, 0), "R9 no-ack");
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, sts(0, 0, 0, 0), "R9 ack");
    chk("R10 irq cleared", host_irq, 0);

    // R7 / R10 error completion without irq request
    wr(8'h00, 32'h0000_0007);
    finish_rsp(1, 8'h5A);
    rd(8'h04, sts(0, 1, 1, 8'h5A), "R7 err");
    chk("R10 irq gated", host_irq, 0);

    // R8 next command clears error
    wr(8'h04, 32'h0000_0004);
    wr(8'h00, 32'h0000_0107);
    rd(8'h04, sts(1, 0, 0, 0), "R8");
    finish_rsp(0, 8'h00);
    wr(8'h04, 32'h0000_0004);

    // R11 done while idle ignored
    finish_rsp(1, 8'hEE);
    rd(8'h04, sts(0, 0, 0, 0), "R11");
    chk("R11 irq", host_irq, 0);

    // R9 done and ack in same cycle: done wins
    wr(8'h00, 32'h0000_0109);
    finish_rsp(0, 8'h00);
    wr(8'h00, 32'h0000_010A);
    @(negedge clk); #1;
    rsp_done = 1; hst_we = 1; hst_addr = 8'h04; hst_wdata = 32'h4;
    @(posedge clk); #1;
    rsp_done = 0; hst_we = 0;
    rd(8'h04, sts(0, 0, 1, 0), "R9 done wins");
    chk("R10 irq after race", host_irq, 1);

    // R12 unmapped
    rd(8'h40, 32'h0, "R12");
    rd(8'hA0, 32'h0, "R12");
    rd(8'h82, 32'h0, "R12");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule